// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block narrows a wide signed fixed-point word, typically the result of a multiply or an accumulator, into a shorter signed fixed-point word. Each format is fixed at build time by two numbers: the total bit count and the count of integer bits including the sign. Every remaining bit is a fraction bit. The block shifts the input right by the difference in fraction bits so the binary point lines up. It then resolves the bits that the shift discards, and finally deals with any result that falls outside the output range.

Two inputs choose the behaviour on each sample. The first picks either truncation or round-to-nearest. The second picks how an out-of-range result is replaced: wrap in two's complement, clamp to the nearest limit, or force to zero. An overflow flag goes with every output word. The result passes through one register stage. A valid strobe passes through the same stage, so each output word lines up with its own strobe.

Top module: `fxq_requant`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_ovf` and `out_data` are all zero.
- R2: `out_valid` on each clock equals `in_valid` one clock earlier.
- R3: With `q_mode` = 0 (truncate), the output value is the input shifted right arithmetically by SHIFT = (IN_WL−IN_IWL) − (OUT_WL−OUT_IWL) bits, which rounds toward minus infinity.
- R4: With `q_mode` = 1 (round), half an output LSB is added before the shift. An exact half rounds away from zero, so with the default formats an input of +0x800 gives +1, −0x800 gives −1, and ±0x7FF gives 0.
- R5: `out_ovf` is 1 exactly when the quantized value lies outside [−2^(OUT_WL−1), 2^(OUT_WL−1)−1]. This holds in every overflow mode.
- R6: With `ov_mode` = 0 (wrap), the output is the low OUT_WL bits of the quantized value.
- R7: With `ov_mode` = 1 or 3 (saturate), an out-of-range value becomes 0x7FFF…F if positive or 0x800…0 if negative.
- R8: With `ov_mode` = 2 (zero), an out-of-range value becomes 0.
- R9: On a clock where `in_valid` is 0, `out_data` and `out_ovf` keep their previous values.
- R10: If rounding carries a value across the positive limit, the result is handled as an overflow. With the defaults, input 0x07FFF800 overflows when rounded but gives 0x7FFF with no overflow when truncated.
- R11: An in-range quantized value is passed through unchanged in every overflow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_WL | Signed input, IN_WL−IN_IWL fraction bits |
| q_mode | input | 1 | 0 = truncate, 1 = round to nearest |
| ov_mode | input | 2 | 0 = wrap, 1/3 = saturate, 2 = zero |
| out_valid | output | 1 | Output strobe |
| out_data | output | OUT_WL | Signed output, OUT_WL−OUT_IWL fraction bits |
| out_ovf | output | 1 | Result was out of range |

## Verification
Small values with every fraction pattern around the half point, both positive and negative, separate truncation from rounding and show the tie-away-from-zero rule. Values just inside and just outside each limit, fed in all three overflow modes, show whether the range test and each replacement rule are correct. One input sits at the positive limit so that rounding alone pushes it over, which shows whether overflow is checked after rounding or before. Random words with random modes, mixed with idle cycles whose data changes, cover the hold behaviour and the combinations the directed cases miss.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
    typedef enum logic [1:0] {
        OVF_WRAP     = 2'd0,
        OVF_SAT      = 2'd1,
        OVF_ZERO     = 2'd2,
        OVF_SAT_ALT  = 2'd3
    } ovf_mode_e;

    typedef enum logic {
        QNT_TRUNC = 1'b0,
        QNT_ROUND = 1'b1
    } qnt_mode_e;
endpackage

// File: rtl/fxq_align_round.sv
module fxq_align_round #(
    parameter int IN_WL = 32,
    parameter int SHIFT = 12,
    localparam int Q_W  = IN_WL + 1 - SHIFT
) (
    input  logic [IN_WL-1:0] din,
    input  logic             rnd_en,
    output logic [Q_W-1:0]   q
);
    logic [IN_WL:0] ext;
    assign ext = {din[IN_WL-1], din};

    generate
        if (SHIFT == 0) begin : g_noshift
            assign q = ext;
        end else begin : g_shift
            localparam logic [IN_WL:0] HALF = (IN_WL+1)'(1) << (SHIFT - 1);
            logic [IN_WL:0] bias;
            logic [IN_WL:0] sum;
            always_comb begin
                if (!rnd_en)
                    bias = '0;
                else if (din[IN_WL-1])
                    bias = HALF - (IN_WL+1)'(1);
                else
                    bias = HALF;
                sum = ext + bias;
            end
            assign q = sum[IN_WL:SHIFT];
        end
    endgenerate
endmodule

// File: rtl/fxq_range_fix.sv
module fxq_range_fix
    import fxq_pkg::*;
#(
    parameter int Q_W    = 21,
    parameter int OUT_WL = 16
) (
    input  logic [Q_W-1:0]    q,
    input  logic [1:0]        mode,
    output logic [OUT_WL-1:0] dout,
    output logic              ovf
);
    localparam logic [OUT_WL-1:0] POS_LIM = {1'b0, {(OUT_WL-1){1'b1}}};
    localparam logic [OUT_WL-1:0] NEG_LIM = {1'b1, {(OUT_WL-1){1'b0}}};

    generate
        if (Q_W > OUT_WL) begin : g_check
            logic [Q_W-OUT_WL:0] top;
            assign top = q[Q_W-1:OUT_WL-1];
            assign ovf = !((&top) || !(|top));
        end else begin : g_fits
            assign ovf = 1'b0;
        end
    endgenerate

    ovf_mode_e m;
    assign m = ovf_mode_e'(mode);

    always_comb begin
        dout = q[OUT_WL-1:0];
        if (ovf) begin
            unique case (m)
                OVF_WRAP:             dout = q[OUT_WL-1:0];
                OVF_SAT, OVF_SAT_ALT: dout = q[Q_W-1] ? NEG_LIM : POS_LIM;
                OVF_ZERO:             dout = '0;
                default:              dout = q[OUT_WL-1:0];
            endcase
        end
    end
endmodule

// File: rtl/fxq_requant.sv
module fxq_requant
    import fxq_pkg::*;
#(
    parameter int IN_WL   = 32,
    parameter int IN_IWL  = 8,
    parameter int OUT_WL  = 16,
    parameter int OUT_IWL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_WL-1:0]  in_data,
    input  logic              q_mode,
    input  logic [1:0]        ov_mode,
    output logic              out_valid,
    output logic [OUT_WL-1:0] out_data,
    output logic              out_ovf
);
    localparam int IN_FWL  = IN_WL - IN_IWL;
    localparam int OUT_FWL = OUT_WL - OUT_IWL;
    localparam int SHIFT   = IN_FWL - OUT_FWL;
    localparam int Q_W     = IN_WL + 1 - SHIFT;

    logic [Q_W-1:0]    q_val;
    logic [OUT_WL-1:0] fixed;
    logic              fix_ovf;
    qnt_mode_e         qm;

    assign qm = qnt_mode_e'(q_mode);

    fxq_align_round #(
        .IN_WL (IN_WL),
        .SHIFT (SHIFT)
    ) u_align (
        .din    (in_data),
        .rnd_en (qm == QNT_ROUND),
        .q      (q_val)
    );

    fxq_range_fix #(
        .Q_W    (Q_W),
        .OUT_WL (OUT_WL)
    ) u_range (
        .q    (q_val),
        .mode (ov_mode),
        .dout (fixed),
        .ovf  (fix_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= fixed;
                out_ovf  <= fix_ovf;
            end
        end
    end
endmodule

// File: rtl/fxq_requant_chk.sv
module fxq_requant_chk #(
    parameter int OUT_WL = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        ov_mode,
    input logic              out_valid,
    input logic [OUT_WL-1:0] out_data,
    input logic              out_ovf
);
    localparam logic [OUT_WL-1:0] POS_LIM = {1'b0, {(OUT_WL-1){1'b1}}};
    localparam logic [OUT_WL-1:0] NEG_LIM = {1'b1, {(OUT_WL-1){1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !out_ovf && out_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

    // R7
    sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ov_mode[0]) |=> (!out_ovf || out_data == POS_LIM || out_data == NEG_LIM));

    // R8
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ov_mode == 2'd2) |=> (!out_ovf || out_data == '0));

    // R5
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ovf) |-> $past(in_valid));
endmodule

bind fxq_requant fxq_requant_chk #(.OUT_WL(OUT_WL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ov_mode   (ov_mode),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
);

// File: tb/test_fxq_requant.sv
module test_fxq_requant;
    localparam int IN_WL = 32, IN_IWL = 8, OUT_WL = 16, OUT_IWL = 4;
    localparam int S = (IN_WL - IN_IWL) - (OUT_WL - OUT_IWL);
    localparam longint MAXV = (64'sd1 <<< (OUT_WL-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (OUT_WL-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_WL-1:0] in_data = '0;
    logic q_mode = 1'b0;
    logic [1:0] ov_mode = 2'd0;
    logic out_valid;
    logic [OUT_WL-1:0] out_data;
    logic out_ovf;

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit finished = 0;

    logic exp_valid, exp_ovf;
    logic [OUT_WL-1:0] exp_data;

    always #10 clk = ~clk;

    fxq_requant #(.IN_WL(IN_WL), .IN_IWL(IN_IWL), .OUT_WL(OUT_WL), .OUT_IWL(OUT_IWL)) i_fxq_requant (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .q_mode(q_mode), .ov_mode(ov_mode), .out_valid(out_valid),
        .out_data(out_data), .out_ovf(out_ovf)
    );

    // Behavioural reference, one register stage deep
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_data  <= '0;
            exp_ovf   <= 1'b0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                longint x, q;
                bit o;
                x = longint'($signed(in_data));
                if (q_mode) begin
                    if (x >= 0) x = x + (64'sd1 <<< (S-1));
                    else        x = x + (64'sd1 <<< (S-1)) - 1;
                end
                q = x >>> S;
                o = (q > MAXV) || (q < MINV);
                exp_ovf <= o;
                if (!o)                exp_data <= q[OUT_WL-1:0];
                else if (ov_mode == 0) exp_data <= q[OUT_WL-1:0];
                else if (ov_mode == 2) exp_data <= '0;
                else                   exp_data <= (q > 0) ? MAXV[OUT_WL-1:0] : MINV[OUT_WL-1:0];
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (out_valid !== exp_valid || out_data !== exp_data || out_ovf !== exp_ovf) begin
                mismatched++;
                $display("FAIL %s: got v=%0b d=%h o=%0b, expected v=%0b d=%h o=%0b",
                         cur_req, out_valid, out_data, out_ovf, exp_valid, exp_data, exp_ovf);
            end
        end
    end

    task automatic put(input logic [IN_WL-1:0] d, input logic qm, input logic [1:0] om);
        @(posedge clk); #5;
        in_valid = 1'b1; in_data = d; q_mode = qm; ov_mode = om;
    endtask

    task automatic idle(input logic [IN_WL-1:0] d);
        @(posedge clk); #5;
        in_valid = 1'b0; in_data = d; q_mode = ~q_mode; ov_mode = ov_mode + 2'd1;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        cur_req = "R3";
        put(32'h0000_1FFF, 0, 0);
        put(32'hFFFF_FFFF, 0, 0);
        put(32'hFFFF_E001, 0, 1);
        cur_req = "R4";
        put(32'h0000_0800, 1, 0);
        put(32'hFFFF_F800, 1, 0);
        put(32'h0000_07FF, 1, 1);
        put(32'hFFFF_F801, 1, 2);
        put(32'h0000_3C00, 1, 0);
        cur_req = "R10";
        put(32'h07FF_F800, 1, 1);
        put(32'h07FF_F800, 0, 1);
        put(32'h07FF_F800, 1, 2);
        cur_req = "R6";
        put(32'h1000_0000, 0, 0);
        put(32'h8000_0000, 0, 0);
        cur_req = "R7";
        put(32'h1000_0000, 0, 1);
        put(32'h8000_0000, 0, 3);
        put(32'hF7FF_FFFF, 1, 1);
        cur_req = "R8";
        put(32'h1234_5678, 0, 2);
        put(32'h8000_0000, 1, 2);
        cur_req = "R11";
        put(32'hF800_0000, 0, 2);
        put(32'h07FF_F000, 0, 1);
        put(32'h0123_4567, 1, 0);
        cur_req = "R9";
        put(32'h1000_0000, 0, 1);
        idle(32'h0000_0000);
        idle(32'h7FFF_FFFF);
        cur_req = "R2";
        put(32'h0000_1000, 0, 0);
        idle(32'h0);
        put(32'h0000_2000, 0, 0);
        cur_req = "R5";
        for (int i = 0; i < 400; i++) begin
            logic [IN_WL-1:0] r;
            r = $urandom;
            if (i % 3 == 0) r = {{5{r[31]}}, r[26:0]};
            if (i % 7 == 0) idle(r);
            else put(r, 1'($urandom), 2'($urandom));
        end
        idle(32'h0);
        repeat (3) @(posedge clk);
        cur_req = "R1";
        #5 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            mismatched++;
            compared++;
            $display("FAIL watchdog %s: got timeout, expected completion", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule